// File: doc/BRIEF.md
# Predicated Register Arithmetic Execute Unit

This block is the single-issue execute stage of a small 16-bit register machine. It owns a file of 32 sixteen-bit registers and two condition flags, called A and B. The highest register doubles as the program counter. Each cycle the unit presents the program counter as a fetch address. The instruction memory returns the word at that address and the word at the next address in the same cycle. The unit then executes the instruction formed by the two words.

Every instruction carries its own predicate on the two flags. If the predicate fails, the instruction is skipped. If it passes, the unit decodes the class and the operation. The only operation implemented is an add. It can wrap silently, or it can record an unsigned carry or a signed overflow into a chosen flag. It can also write the bitwise complement of the sum. Any class or operation the unit does not support stops it, and it stays stopped until reset.

Control is a two-state machine. `ST_RUN` executes one instruction per cycle. The transition `run_to_halt` fires when a predicated-in instruction has an unsupported class or operation. `ST_HALT` has only the self-loop `halt_hold` and is left only through reset, which enters `ST_RUN`.

Top module: `pred_exec_unit`

## Requirements
- R1: Reset clears all 32 registers, which sets the program counter and fetch address to 0. It also clears both flags, deasserts halt and enters ST_RUN.
- R2: The fetch address equals the program counter. After every instruction that does not halt, whether executed or skipped, the program counter becomes its old value plus 2, modulo 2^16.
- R3: First word bits 15/14 enable a check of flag A/B, and bits 13/12 give the value each flag must have. If any enabled check mismatches, the instruction writes no register and no flag.
- R4: When the predicate passes and first word bits 11:8 are not 1 (arithmetic), the unit halts and writes no register and no flag.
- R5: Operation 0 (first word bits 3:0) writes src1+src2 modulo 2^16 to the destination. Second word bits 15:11 give src1, bits 10:6 give src2 and bits 5:1 give the destination. With first word bit 6 (C) clear, neither flag changes.
- R6: With C=1 and bit 7 (S) clear, the unsigned carry out of the add is written to flag A when bit 5 is 0, or to flag B when bit 5 is 1.
- R7: With C=1 and S=1, the two's-complement signed overflow of the add is written to the flag chosen by bit 5.
- R8: With bit 4 (I) set, the destination receives the bitwise complement of the sum. The flag value is computed from the sum before it is complemented.
- R9: A destination of register 31 writes nothing to the register file (wb_en low). The flag update still occurs, and the program counter advances by 2.
- R10: Operation 1 is reserved and behaves as a no-op that advances the program counter. Operations 2 to 15 halt without writing any register or flag.
- R11: Once halted, halt stays high and the program counter, flags and registers stay frozen until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_addr | output | 16 | Instruction fetch address (program counter) |
| insn_w0 | input | 16 | Instruction word at fetch_addr |
| insn_w1 | input | 16 | Instruction word at fetch_addr+1 |
| halt | output | 1 | Unit has stopped on an unsupported instruction |
| flag_a | output | 1 | Condition flag A |
| flag_b | output | 1 | Condition flag B |
| wb_en | output | 1 | A register write occurs at the coming edge |
| wb_idx | output | 5 | Index of the register being written |
| wb_data | output | 16 | Value being written |

## Verification
The assertions assume that both instruction words are stable and valid for the whole cycle that follows a fetch-address change. The bench meets this by serving both words combinationally from a 256-word array indexed by the low fetch-address bits. It changes the array contents only while reset is held. Reset is driven low from time zero, so the past-value checks never see pre-reset state. Random programs mix predicate patterns, all four option bits, reserved and illegal operations, and rare illegal classes, so runs reach both long execution and the halted state.

// File: rtl/pexu_pkg.sv
package pexu_pkg;
    localparam int INSN_W    = 16;
    localparam int POS_EN_A  = 15;
    localparam int POS_EN_B  = 14;
    localparam int POS_REQ_A = 13;
    localparam int POS_REQ_B = 12;
    localparam int POS_SGN   = 7;
    localparam int POS_CHK   = 6;
    localparam int POS_FSEL  = 5;
    localparam int POS_INV   = 4;
    localparam logic [3:0] CLS_ARITH = 4'h1;
    localparam logic [3:0] OP_ADD    = 4'h0;
    localparam logic [3:0] OP_RSV    = 4'h1;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_HALT = 1'b1
    } exu_state_t;
endpackage

// File: rtl/pexu_predicate.sv
module pexu_predicate
    import pexu_pkg::*;
(
    input  logic [3:0] pred_field,
    input  logic       cur_a,
    input  logic       cur_b,
    output logic       pass
);
    logic miss_a;
    logic miss_b;

    always_comb begin
        miss_a = pred_field[POS_EN_A - 12] && (pred_field[POS_REQ_A - 12] != cur_a);
        miss_b = pred_field[POS_EN_B - 12] && (pred_field[POS_REQ_B - 12] != cur_b);
        pass   = !(miss_a || miss_b);
    end
endmodule

// File: rtl/pexu_adder.sv
module pexu_adder #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic              use_signed,
    input  logic              invert,
    output logic [DATA_W-1:0] result,
    output logic              flag_val
);
    logic [DATA_W:0] wide_sum;
    logic            carry_out;
    logic            sgn_ovf;

    always_comb begin
        wide_sum  = {1'b0, opnd_a} + {1'b0, opnd_b};
        carry_out = wide_sum[DATA_W];
        sgn_ovf   = (opnd_a[DATA_W-1] == opnd_b[DATA_W-1]) &&
                    (wide_sum[DATA_W-1] != opnd_a[DATA_W-1]);
        flag_val  = use_signed ? sgn_ovf : carry_out;
        result    = invert ? ~wide_sum[DATA_W-1:0] : wide_sum[DATA_W-1:0];
    end
endmodule

// File: rtl/pexu_regfile.sv
module pexu_regfile #(
    parameter int DATA_W    = 16,
    parameter int REG_COUNT = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [$clog2(REG_COUNT)-1:0] rd_a_idx,
    input  logic [$clog2(REG_COUNT)-1:0] rd_b_idx,
    output logic [DATA_W-1:0]            rd_a_data,
    output logic [DATA_W-1:0]            rd_b_data,
    input  logic                         wr_en,
    input  logic [$clog2(REG_COUNT)-1:0] wr_idx,
    input  logic [DATA_W-1:0]            wr_data,
    input  logic                         pc_en,
    input  logic [DATA_W-1:0]            pc_next,
    output logic [DATA_W-1:0]            pc_cur
);
    localparam int PC_IDX = REG_COUNT - 1;

    logic [DATA_W-1:0] regs [REG_COUNT];

    genvar gi;
    generate
        for (gi = 0; gi < REG_COUNT; gi++) begin : g_reg
            if (gi == PC_IDX) begin : g_pc
                always_ff @(posedge clk) begin
                    if (!rst_n)     regs[gi] <= '0;
                    else if (pc_en) regs[gi] <= pc_next;
                end
            end else begin : g_gpr
                always_ff @(posedge clk) begin
                    if (!rst_n)
                        regs[gi] <= '0;
                    else if (wr_en && (wr_idx == gi[$clog2(REG_COUNT)-1:0]))
                        regs[gi] <= wr_data;
                end
            end
        end
    endgenerate

    assign rd_a_data = regs[rd_a_idx];
    assign rd_b_data = regs[rd_b_idx];
    assign pc_cur    = regs[PC_IDX];
endmodule

// File: rtl/pred_exec_unit.sv
module pred_exec_unit
    import pexu_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int REG_COUNT = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    output logic [DATA_W-1:0]            fetch_addr,
    input  logic [INSN_W-1:0]            insn_w0,
    input  logic [INSN_W-1:0]            insn_w1,
    output logic                         halt,
    output logic                         flag_a,
    output logic                         flag_b,
    output logic                         wb_en,
    output logic [$clog2(REG_COUNT)-1:0] wb_idx,
    output logic [DATA_W-1:0]            wb_data
);
    localparam int AW     = $clog2(REG_COUNT);
    localparam int PC_IDX = REG_COUNT - 1;
    localparam logic [AW-1:0] PC_SEL = AW'(PC_IDX);

    exu_state_t state_q, state_d;

    logic [AW-1:0]     src1, src2, dst;
    logic [3:0]        cls, opc;
    logic              pred_ok, running, is_arith, halt_req, do_add, flag_we;
    logic [DATA_W-1:0] opnd_a, opnd_b, add_res, pc;
    logic              add_flag;
    logic              unused_w1_lsb;

    assign src1 = insn_w1[INSN_W-1 -: AW];
    assign src2 = insn_w1[INSN_W-1-AW -: AW];
    assign dst  = insn_w1[AW:1];
    assign cls  = insn_w0[11:8];
    assign opc  = insn_w0[3:0];
    assign unused_w1_lsb = insn_w1[0];

    pexu_predicate u_pred (
        .pred_field (insn_w0[15:12]),
        .cur_a      (flag_a),
        .cur_b      (flag_b),
        .pass       (pred_ok)
    );

    pexu_regfile #(.DATA_W(DATA_W), .REG_COUNT(REG_COUNT)) u_rf (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_a_idx  (src1),
        .rd_b_idx  (src2),
        .rd_a_data (opnd_a),
        .rd_b_data (opnd_b),
        .wr_en     (wb_en),
        .wr_idx    (wb_idx),
        .wr_data   (wb_data),
        .pc_en     (running && !halt_req),
        .pc_next   (pc + DATA_W'(2)),
        .pc_cur    (pc)
    );

    pexu_adder #(.DATA_W(DATA_W)) u_add (
        .opnd_a     (opnd_a),
        .opnd_b     (opnd_b),
        .use_signed (insn_w0[POS_SGN]),
        .invert     (insn_w0[POS_INV]),
        .result     (add_res),
        .flag_val   (add_flag)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // Next state and outputs
    always_comb begin
        running  = (state_q == ST_RUN);
        is_arith = (cls == CLS_ARITH);
        halt_req = running && pred_ok &&
                   (!is_arith || !((opc == OP_ADD) || (opc == OP_RSV)));
        do_add   = running && pred_ok && is_arith && (opc == OP_ADD);
        flag_we  = do_add && insn_w0[POS_CHK];
        wb_en    = do_add && (dst != PC_SEL);
        wb_idx   = dst;
        wb_data  = add_res;
        halt     = !running;
        state_d  = state_q;
        unique case (state_q)
            ST_RUN:  if (halt_req) state_d = ST_HALT;   // run_to_halt
            ST_HALT: state_d = ST_HALT;                 // halt_hold
        endcase
    end

    assign fetch_addr = pc;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_a <= 1'b0;
            flag_b <= 1'b0;
        end else if (flag_we) begin
            if (insn_w0[POS_FSEL]) flag_b <= add_flag;
            else                   flag_a <= add_flag;
        end
    end

    assert_pc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !halt_req) |=> (fetch_addr == $past(fetch_addr) + DATA_W'(2)));

    assert_skip_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !pred_ok) |=> ($stable(flag_a) && $stable(flag_b) && !$past(wb_en)));

    assert_halt_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        halt_req |=> (halt && $stable(flag_a) && $stable(flag_b)));

    assert_no_flag_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !insn_w0[POS_CHK]) |=> ($stable(flag_a) && $stable(flag_b)));

    assert_pc_not_written_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> (wb_idx != PC_SEL));

    assert_halt_no_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        halt_req |-> !wb_en);

    assert_halt_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> (halt && $stable(fetch_addr) && $stable(flag_a) && $stable(flag_b) && !wb_en));
endmodule

// File: tb/test_pred_exec_unit.sv
module test_pred_exec_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] fetch_addr, insn_w0, insn_w1, wb_data;
    logic        halt, flag_a, flag_b, wb_en;
    logic [4:0]  wb_idx;

    logic [15:0] mem [256];
    int n_checks = 0;
    int n_fail   = 0;

    logic [15:0] mr [32];
    logic        mfa, mfb, mhalt;

    always #5 clk = ~clk;

    assign insn_w0 = mem[fetch_addr[7:0]];
    assign insn_w1 = mem[fetch_addr[7:0] + 8'd1];

    pred_exec_unit i_pred_exec_unit (
        .clk(clk), .rst_n(rst_n), .fetch_addr(fetch_addr),
        .insn_w0(insn_w0), .insn_w1(insn_w1), .halt(halt),
        .flag_a(flag_a), .flag_b(flag_b), .wb_en(wb_en),
        .wb_idx(wb_idx), .wb_data(wb_data)
    );

    task automatic chk(input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        for (int i = 0; i < 32; i++) mr[i] = '0;
        mfa = 1'b0; mfb = 1'b0; mhalt = 1'b0;
        @(negedge clk);
        chk("R1", "pc", fetch_addr, 16'h0);
        chk("R1", "flags", {14'h0, flag_a, flag_b}, 16'h0);
        chk("R1", "halt", {15'h0, halt}, 16'h0);
    endtask

    function automatic logic [15:0] enc1(input int s1, input int s2, input int d);
        return 16'((s1 << 11) | (s2 << 6) | (d << 1));
    endfunction

    // One cycle: compare outputs against model at negedge, then advance model
    task automatic step();
        logic [15:0] w0, w1, a, b, res;
        logic [16:0] sum;
        logic        fv, ewen, pass;
        int          s1, s2, d;
        string       tag;
        w0 = mem[mr[31][7:0]];
        w1 = mem[mr[31][7:0] + 8'd1];
        s1 = int'(w1[15:11]); s2 = int'(w1[10:6]); d = int'(w1[5:1]);
        pass = !((w0[15] && (w0[13] != mfa)) || (w0[14] && (w0[12] != mfb)));
        ewen = 1'b0; res = '0;
        if (mhalt)                    tag = "R11";
        else if (!pass)               tag = "R3";
        else if (w0[11:8] != 4'h1)    tag = "R4";
        else if (w0[3:0] != 4'h0)     tag = "R10";
        else if (d == 31)             tag = "R9";
        else if (w0[4])               tag = "R8";
        else if (w0[6] && w0[7])      tag = "R7";
        else if (w0[6])               tag = "R6";
        else                          tag = "R5";
        chk("R2", "pc", fetch_addr, mr[31]);
        chk(tag, "halt", {15'h0, halt}, {15'h0, mhalt});
        chk(tag, "flags", {14'h0, flag_a, flag_b}, {14'h0, mfa, mfb});
        if (!mhalt) begin
            if (!pass || (w0[11:8] == 4'h1 && w0[3:0] == 4'h1)) begin
                mr[31] = mr[31] + 16'd2;
            end else if (w0[11:8] != 4'h1 || w0[3:0] != 4'h0) begin
                mhalt = 1'b1;
            end else begin
                a = mr[s1]; b = mr[s2];
                sum = {1'b0, a} + {1'b0, b};
                fv = w0[7] ? ((a[15] == b[15]) && (sum[15] != a[15])) : sum[16];
                res = w0[4] ? ~sum[15:0] : sum[15:0];
                if (w0[6]) begin
                    if (w0[5]) mfb = fv; else mfa = fv;
                end
                if (d != 31) begin
                    ewen = 1'b1;
                    mr[d] = res;
                end
                mr[31] = mr[31] + 16'd2;
            end
        end
        chk(tag, "wb_en", {15'h0, wb_en}, {15'h0, ewen});
        if (ewen) begin
            chk(tag, "wb_idx", {11'h0, wb_idx}, 16'(d));
            chk(tag, "wb_data", wb_data, res);
        end
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL R11 watchdog: actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        // Directed program
        for (int i = 0; i < 256; i++) mem[i] = 16'h0;
        mem[0]  = 16'h0110; mem[1]  = enc1(0, 0, 1);   // r1 = ~0 (R8)
        mem[2]  = 16'h0140; mem[3]  = enc1(1, 1, 2);   // carry -> A (R6)
        mem[4]  = 16'hA100; mem[5]  = enc1(1, 1, 4);   // needs A=1 (R3 pass)
        mem[6]  = 16'h8100; mem[7]  = enc1(1, 1, 5);   // needs A=0, skipped (R3)
        mem[8]  = 16'h0110; mem[9]  = enc1(2, 0, 3);   // r3 = ~FFFE = 0001
        mem[10] = 16'h0110; mem[11] = enc1(1, 3, 6);   // r6 = ~(0000) = FFFF
        mem[12] = 16'h0100; mem[13] = enc1(1, 2, 7);   // wrap add no flag (R5)
        mem[14] = 16'h0110; mem[15] = enc1(0, 0, 8);   // r8 = FFFF
        mem[16] = 16'h0130; mem[17] = enc1(8, 3, 9);   // r9 = ~0000... flag unchanged
        mem[18] = 16'h01E0; mem[19] = enc1(2, 2, 10);  // signed, C, F=B (R7)
        mem[20] = 16'h0160; mem[21] = enc1(1, 1, 31);  // dest PC, flag B still (R9)
        mem[22] = 16'h0101; mem[23] = enc1(1, 1, 11);  // reserved op (R10)
        mem[24] = 16'h0105; mem[25] = enc1(1, 1, 12);  // illegal op halts (R10)
        do_reset();
        repeat (20) step();
        // Illegal class halts (R4)
        mem[24] = 16'h0300;
        do_reset();
        repeat (20) step();
        // Random programs
        for (int p = 0; p < 40; p++) begin
            rst_n = 1'b0;
            for (int i = 0; i < 256; i += 2) begin
                int r;
                logic [3:0] cl, op;
                r  = int'($urandom % 200);
                cl = (r == 0) ? 4'h3 : 4'h1;
                op = (r == 1) ? 4'h9 : ((r % 6 == 0) ? 4'h1 : 4'h0);
                mem[i]   = {4'($urandom), cl, 4'($urandom), op};
                mem[i+1] = 16'($urandom);
            end
            do_reset();
            repeat (400) step();
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule